// File: doc/BRIEF.md
# Voice Controller Serial Host Port

This block is the host-facing serial port of a voice record and playback controller. A host talks to it over four plain wires: an active-low select (`sel_n`), a serial data input (`sdi`), a serial data output (`sdo`) and a bit strobe (`strobe`). The port keeps the start address, the end address and the control word that the address sequencer reads. It also returns a status byte and the two address counters to the host.

After system reset the port is in manual mode and ignores all serial traffic. A low pulse on `sel_n` moves it into host mode. A low pulse on `rt_n`, with `sel_n` held high, moves it back to manual mode and keeps the register contents. In host mode, each frame is marked by `sel_n` being low. Data bits are taken on falling edges of `strobe`, most significant bit first. The first four bits form a command code. For a write command, the code fixes the payload length, and the payload reaches its register only after its last bit has arrived. For a read command, the first bit of the reply is on `sdo` as soon as the command is complete. Each later rising edge of `strobe` moves the reply on by one bit.

The serial pins are plain level signals paced by the host, so there is no valid/ready handshake and no back-pressure. All pins are sampled on `clk` and must already be synchronous to it. `strobe` must stay at each level for at least one clock.

Top module: `voice_host_port`

## Requirements
- R1: After `rst_n` is asserted, `host_mode` is 0, `start_addr`, `end_addr` and `ctrl_word` are 0, and `sdo` is 0.
- R2: In manual mode, a frame on `sel_n` writes no register. The rising edge of `sel_n` that ends a low pulse moves the port into host mode (`host_mode` = 1).
- R3: A rising edge of `rt_n` while `sel_n` is high returns the port to manual mode. A pulse on `rt_n` while `sel_n` is low has no effect. All registers keep their values across the mode change.
- R4: In host mode, with `sel_n` low, `sdi` is sampled on each falling edge of `strobe`, most significant bit first. The first four sampled bits are the command code.
- R5: Command 4'b0001 takes a 10-bit payload and loads it into `start_addr`.
- R6: Command 4'b0010 takes an 8-bit payload and loads it into `ctrl_word`. The decoded fields are:
  - `comp_en` = bit 7
  - `comp_param` = bits 6:5
  - `sig_valid` = bits 4:3
  - `lpf_narrow` = bit 2 (0 selects the 3.4 kHz cutoff, 1 selects the 2.7 kHz cutoff)
- R7: Command 4'b0011 takes a 16-bit payload and loads it into `end_addr`.
- R8: A register changes only when the last payload bit is sampled. If `sel_n` rises before that, including in the same clock as the final falling edge of `strobe`, the payload is dropped.
- R9: Any other command code, and any bit that follows a completed command, is ignored until `sel_n` goes high.
- R10: Command 4'b1000 returns `status_in` as one byte. Its MSB is on `sdo` right after the command, each rising edge of `strobe` advances one bit, and after 8 bits `sdo` is 0.
- R11: Command 4'b1001 returns one byte holding `ext_cnt_in`, zero-extended. Command 4'b1010 returns `main_cnt_in` as two bytes, high byte first. The value is captured when the command completes.
- R12: `sdo` is 0 whenever `sel_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rt_n | input | 1 | Active-low return-to-manual pulse input |
| sel_n | input | 1 | Active-low host select / mode-entry pulse |
| sdi | input | 1 | Serial data from host |
| strobe | input | 1 | Bit strobe; fall samples `sdi`, rise advances `sdo` |
| status_in | input | 8 | Status byte to report |
| ext_cnt_in | input | 6 | Extended address counter to report |
| main_cnt_in | input | 16 | Main address counter to report |
| sdo | output | 1 | Serial data to host |
| host_mode | output | 1 | 1 in host mode, 0 in manual mode |
| start_addr | output | 10 | Start address register |
| end_addr | output | 16 | End address register |
| ctrl_word | output | 8 | Control word register |
| comp_en | output | 1 | Compression enable (control bit 7) |
| comp_param | output | 2 | Compression parameters (control bits 6:5) |
| sig_valid | output | 2 | Signal-valid selects (control bits 4:3) |
| lpf_narrow | output | 1 | Filter cutoff select (control bit 2) |

## Verification
The register commit for the last payload bit and the end of the frame on `sel_n` can land in the same clock. The bench provokes this by lowering `strobe` for the final start-address bit on the same clock edge where it raises `sel_n`. It judges the result by reading `start_addr` at the port: the earlier value must remain, because a bit is only taken while the frame is open. A second overlap exercises mode entry against frame framing: the pulse that enters host mode must not itself be treated as a write.

// File: rtl/voice_host_pkg.sv
package voice_host_pkg;
  localparam logic [3:0] CMD_WR_START = 4'b0001;
  localparam logic [3:0] CMD_WR_CTRL  = 4'b0010;
  localparam logic [3:0] CMD_WR_END   = 4'b0011;
  localparam logic [3:0] CMD_RD_STAT  = 4'b1000;
  localparam logic [3:0] CMD_RD_EXT   = 4'b1001;
  localparam logic [3:0] CMD_RD_MAIN  = 4'b1010;
  localparam int CMD_BITS = 4;
  localparam int CTRL_W   = 8;
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {RX_CMD, RX_PAY, RX_READ, RX_DONE} rx_state_e;
  typedef enum logic [1:0] {TGT_START, TGT_CTRL, TGT_END} wr_tgt_e;
  typedef enum logic [1:0] {SRC_STAT, SRC_EXT, SRC_MAIN} rd_src_e;
endpackage

// File: rtl/voice_host_mode.sv
module voice_host_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic rt_n,
  output logic host_mode
);
  logic sel_q, rt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_mode <= 1'b0;
      sel_q     <= 1'b1;
      rt_q      <= 1'b1;
    end else begin
      sel_q <= sel_n;
      rt_q  <= rt_n;
      if (!host_mode && !sel_q && sel_n)
        host_mode <= 1'b1;
      else if (host_mode && !rt_q && rt_n && sel_n)
        host_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/voice_host_rx.sv
module voice_host_rx
  import voice_host_pkg::*;
#(
  parameter int START_W = 10,
  parameter int END_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             fall,
  input  logic             sdi,
  output logic             wr_stb,
  output wr_tgt_e          wr_tgt,
  output logic [END_W-1:0] wr_data,
  output logic             rd_stb,
  output rd_src_e          rd_src
);
  localparam int PAY_W = END_W;
  localparam int CNT_W = $clog2(PAY_W + 1) < 3 ? 3 : $clog2(PAY_W + 1);

  rx_state_e        state;
  logic [2:0]       cmd_sr;
  logic [PAY_W-1:0] pay_sr;
  logic [CNT_W-1:0] cnt, plen, d_len;
  wr_tgt_e          d_tgt;
  logic             is_wr, is_rd;
  logic [3:0]       cmd_full;

  assign cmd_full = {cmd_sr, sdi};

  always_comb begin
    is_wr  = 1'b0;
    is_rd  = 1'b0;
    d_len  = CNT_W'(CTRL_W);
    d_tgt  = TGT_CTRL;
    rd_src = SRC_STAT;
    case (cmd_full)
      CMD_WR_START: begin is_wr = 1'b1; d_len = CNT_W'(START_W); d_tgt = TGT_START; end
      CMD_WR_CTRL:  begin is_wr = 1'b1; d_len = CNT_W'(CTRL_W);  d_tgt = TGT_CTRL;  end
      CMD_WR_END:   begin is_wr = 1'b1; d_len = CNT_W'(END_W);   d_tgt = TGT_END;   end
      CMD_RD_STAT:  begin is_rd = 1'b1; rd_src = SRC_STAT; end
      CMD_RD_EXT:   begin is_rd = 1'b1; rd_src = SRC_EXT;  end
      CMD_RD_MAIN:  begin is_rd = 1'b1; rd_src = SRC_MAIN; end
      default: ;
    endcase
  end

  assign wr_data = {pay_sr[PAY_W-2:0], sdi};
  assign wr_stb  = active && fall && (state == RX_PAY) && (cnt == plen - 1'b1);
  assign rd_stb  = active && fall && (state == RX_CMD) &&
                   (cnt == CNT_W'(CMD_BITS - 1)) && is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_CMD;
      cmd_sr <= '0;
      pay_sr <= '0;
      cnt    <= '0;
      plen   <= '0;
      wr_tgt <= TGT_CTRL;
    end else if (!active) begin
      state <= RX_CMD;
      cnt   <= '0;
    end else if (fall) begin
      case (state)
        RX_CMD: begin
          cmd_sr <= cmd_full[2:0];
          if (cnt == CNT_W'(CMD_BITS - 1)) begin
            cnt    <= '0;
            plen   <= d_len;
            wr_tgt <= d_tgt;
            state  <= is_wr ? RX_PAY : (is_rd ? RX_READ : RX_DONE);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_PAY: begin
          pay_sr <= wr_data;
          if (cnt == plen - 1'b1) state <= RX_DONE;
          else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/voice_host_tx.sv
module voice_host_tx
  import voice_host_pkg::*;
#(
  parameter int EXT_W  = 6,
  parameter int MAIN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rise,
  input  logic              rd_stb,
  input  rd_src_e           rd_src,
  input  logic [BYTE_W-1:0] status_in,
  input  logic [EXT_W-1:0]  ext_in,
  input  logic [MAIN_W-1:0] main_in,
  output logic              sdo
);
  localparam int OUT_W = ((MAIN_W + BYTE_W - 1) / BYTE_W) * BYTE_W;
  localparam int LW    = $clog2(OUT_W + 1);

  logic [OUT_W-1:0] out_sr;
  logic [LW-1:0]    left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr <= '0;
      left   <= '0;
    end else if (!active) begin
      left <= '0;
    end else if (rd_stb) begin
      case (rd_src)
        SRC_STAT: begin out_sr <= OUT_W'(status_in) << (OUT_W - BYTE_W); left <= LW'(BYTE_W); end
        SRC_EXT:  begin out_sr <= OUT_W'(ext_in) << (OUT_W - BYTE_W);    left <= LW'(BYTE_W); end
        default:  begin out_sr <= OUT_W'(main_in);                       left <= LW'(OUT_W);  end
      endcase
    end else if (rise && left != '0) begin
      out_sr <= out_sr << 1;
      left   <= left - 1'b1;
    end
  end

  assign sdo = active && (left != '0) && out_sr[OUT_W-1];
endmodule

// File: rtl/voice_host_port.sv
module voice_host_port
  import voice_host_pkg::*;
#(
  parameter int START_W = 10,
  parameter int END_W   = 16,
  parameter int EXT_W   = 6,
  parameter int MAIN_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rt_n,
  input  logic               sel_n,
  input  logic               sdi,
  input  logic               strobe,
  input  logic [BYTE_W-1:0]  status_in,
  input  logic [EXT_W-1:0]   ext_cnt_in,
  input  logic [MAIN_W-1:0]  main_cnt_in,
  output logic               sdo,
  output logic               host_mode,
  output logic [START_W-1:0] start_addr,
  output logic [END_W-1:0]   end_addr,
  output logic [CTRL_W-1:0]  ctrl_word,
  output logic               comp_en,
  output logic [1:0]         comp_param,
  output logic [1:0]         sig_valid,
  output logic               lpf_narrow
);
  logic             strb_q, active, fall, rise;
  logic             wr_stb, rd_stb;
  wr_tgt_e          wr_tgt;
  rd_src_e          rd_src;
  logic [END_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= strobe;
  end

  assign active = host_mode && !sel_n;
  assign fall   = strb_q && !strobe;
  assign rise   = !strb_q && strobe;

  voice_host_mode u_mode (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rt_n(rt_n), .host_mode(host_mode)
  );

  voice_host_rx #(.START_W(START_W), .END_W(END_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(active), .fall(fall), .sdi(sdi),
    .wr_stb(wr_stb), .wr_tgt(wr_tgt), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_src(rd_src)
  );

  voice_host_tx #(.EXT_W(EXT_W), .MAIN_W(MAIN_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(active), .rise(rise),
    .rd_stb(rd_stb), .rd_src(rd_src), .status_in(status_in),
    .ext_in(ext_cnt_in), .main_in(main_cnt_in), .sdo(sdo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      end_addr   <= '0;
      ctrl_word  <= '0;
    end else if (wr_stb) begin
      case (wr_tgt)
        TGT_START: start_addr <= wr_data[START_W-1:0];
        TGT_CTRL:  ctrl_word  <= wr_data[CTRL_W-1:0];
        default:   end_addr   <= wr_data;
      endcase
    end
  end

  assign comp_en    = ctrl_word[7];
  assign comp_param = ctrl_word[6:5];
  assign sig_valid  = ctrl_word[4:3];
  assign lpf_narrow = ctrl_word[2];
endmodule

// File: rtl/voice_host_port_chk.sv
module voice_host_port_chk #(
  parameter int START_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rt_n,
  input logic               sel_n,
  input logic               sdo,
  input logic               host_mode,
  input logic [START_W-1:0] start_addr,
  input logic [7:0]         ctrl_word
);
  // R2: no register write while in manual mode
  assert_manual_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |=> $stable(start_addr));

  // R2: host mode is entered only when sel_n returns high
  assert_enter_on_sel_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_mode) |-> $past(sel_n));

  // R3: leaving host mode needs rt_n and sel_n high at the change
  assert_exit_needs_sel_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_mode) |-> $past(sel_n && rt_n));

  // R8: control word only changes inside an open host frame
  assert_ctrl_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> $past(host_mode && !sel_n));

  // R12: output quiet outside a frame
  assert_sdo_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !sdo);
endmodule

bind voice_host_port voice_host_port_chk #(.START_W(START_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rt_n(rt_n), .sel_n(sel_n), .sdo(sdo),
  .host_mode(host_mode), .start_addr(start_addr), .ctrl_word(ctrl_word)
);

// File: tb/voice_host_port_bench.sv
module voice_host_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {command, payload}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b0001, 16'h03FF}, {4'b0010, 16'h00A4}, {4'b0011, 16'hBEEF},
    {4'b0001, 16'h0155}, {4'b0011, 16'h0001}, {4'b0010, 16'h005B}
  };

  logic clk = 0, rst_n = 0, rt_n = 1, sel_n = 1, sdi = 0, strobe = 0;
  logic [7:0]  status_in = 8'hA5;
  logic [5:0]  ext_cnt_in = 6'h2B;
  logic [15:0] main_cnt_in = 16'hC35A;
  logic sdo, host_mode, comp_en, lpf_narrow;
  logic [9:0]  start_addr;
  logic [15:0] end_addr;
  logic [7:0]  ctrl_word;
  logic [1:0]  comp_param, sig_valid;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [9:0]  exp_start = '0;
  logic [15:0] exp_end = '0;
  logic [7:0]  exp_ctrl = '0;
  logic [15:0] rv;

  voice_host_port u_voice_host_port (
    .clk(clk), .rst_n(rst_n), .rt_n(rt_n), .sel_n(sel_n), .sdi(sdi),
    .strobe(strobe), .status_in(status_in), .ext_cnt_in(ext_cnt_in),
    .main_cnt_in(main_cnt_in), .sdo(sdo), .host_mode(host_mode),
    .start_addr(start_addr), .end_addr(end_addr), .ctrl_word(ctrl_word),
    .comp_en(comp_en), .comp_param(comp_param), .sig_valid(sig_valid),
    .lpf_narrow(lpf_narrow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    strobe = 1; sdi = b; @(negedge clk);
    strobe = 0; @(negedge clk);
  endtask

  task automatic open_frame();
    sel_n = 0; @(negedge clk);
  endtask

  task automatic close_frame();
    sel_n = 1; @(negedge clk); @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  function automatic int pay_len(input logic [3:0] c);
    return (c == 4'b0001) ? 10 : (c == 4'b0011) ? 16 : 8;
  endfunction

  task automatic write_frame(input logic [3:0] c, input logic [15:0] d);
    open_frame(); send_bits({12'h0, c}, 4); send_bits(d, pay_len(c)); close_frame();
  endtask

  task automatic read_frame(input logic [3:0] c, input int n, input string tag,
                            output logic [15:0] v);
    v = '0;
    open_frame(); send_bits({12'h0, c}, 4);
    v[n-1] = sdo;
    for (int i = n - 2; i >= 0; i--) begin
      strobe = 1; @(negedge clk); v[i] = sdo;
      strobe = 0; @(negedge clk);
    end
    strobe = 1; @(negedge clk);
    chk({tag, " sdo idle after reply"}, 32'(sdo), 0);
    strobe = 0; @(negedge clk);
    close_frame();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 host_mode", 32'(host_mode), 0);
    chk("R1 registers", {start_addr, end_addr, ctrl_word[5:0]}, 0);
    chk("R1 ctrl/sdo", {ctrl_word, 7'b0, sdo}, 0);
    rst_n = 1; @(negedge clk);

    // R2 frame in manual mode writes nothing, then enters host mode
    write_frame(4'b0001, 16'h0123);
    chk("R2 manual write ignored", 32'(start_addr), 0);
    chk("R2 host mode entered", 32'(host_mode), 1);

    // R4 R5 R6 R7 table walk
    for (int k = 0; k < NVEC; k++) begin
      write_frame(VEC[k][19:16], VEC[k][15:0]);
      case (VEC[k][19:16])
        4'b0001: exp_start = VEC[k][9:0];
        4'b0011: exp_end = VEC[k][15:0];
        default: exp_ctrl = VEC[k][7:0];
      endcase
      chk("R5 start_addr", 32'(start_addr), 32'(exp_start));
      chk("R7 end_addr", 32'(end_addr), 32'(exp_end));
      chk("R6 ctrl_word", 32'(ctrl_word), 32'(exp_ctrl));
      chk("R6 fields", {comp_en, comp_param, sig_valid, lpf_narrow},
          {exp_ctrl[7], exp_ctrl[6:5], exp_ctrl[4:3], exp_ctrl[2]});
    end

    // R8 abort mid payload
    open_frame(); send_bits(16'h1, 4); send_bits(16'h3, 5); close_frame();
    chk("R8 partial payload dropped", 32'(start_addr), 32'(exp_start));
    // R8 final strobe fall coinciding with sel_n rise
    open_frame(); send_bits(16'h1, 4); send_bits(16'h0, 9);
    strobe = 1; sdi = 1; @(negedge clk);
    strobe = 0; sel_n = 1; @(negedge clk); @(negedge clk);
    chk("R8 coincident close dropped", 32'(start_addr), 32'(exp_start));

    // R9 unknown command followed by a valid-looking write
    open_frame(); send_bits(16'h5, 4); send_bits(16'h2, 4); send_bits(16'h77, 8); close_frame();
    chk("R9 unknown cmd ignored", 32'(ctrl_word), 32'(exp_ctrl));
    // R9 bits after completed write ignored
    open_frame(); send_bits(16'h1, 4); send_bits(16'h0AA, 10);
    send_bits(16'h3, 4); send_bits(16'hFFFF, 16); close_frame();
    exp_start = 10'h0AA;
    chk("R9 start written", 32'(start_addr), 32'(exp_start));
    chk("R9 trailing bits ignored", 32'(end_addr), 32'(exp_end));

    // R10 status read
    read_frame(4'b1000, 8, "R10", rv);
    chk("R10 status byte", 32'(rv[7:0]), 32'h A5);
    // R11 extended and main counters
    read_frame(4'b1001, 8, "R11", rv);
    chk("R11 ext byte", 32'(rv[7:0]), 32'h2B);
    read_frame(4'b1010, 16, "R11", rv);
    chk("R11 main counter", 32'(rv), 32'hC35A);

    // R12 sdo quiet after sel_n rises during a reply
    open_frame(); send_bits(16'h8, 4);
    chk("R12 sdo msb shown", 32'(sdo), 1);
    sel_n = 1; @(negedge clk);
    chk("R12 sdo quiet", 32'(sdo), 0);
    @(negedge clk);

    // R3 rt pulse while sel_n low has no effect
    sel_n = 0; @(negedge clk); rt_n = 0; @(negedge clk); rt_n = 1; @(negedge clk);
    chk("R3 rt during frame ignored", 32'(host_mode), 1);
    close_frame();
    // R3 rt pulse with sel_n high returns to manual, registers kept
    rt_n = 0; @(negedge clk); rt_n = 1; @(negedge clk); @(negedge clk);
    chk("R3 manual mode", 32'(host_mode), 0);
    chk("R3 registers kept", {start_addr, end_addr, ctrl_word},
        {exp_start, exp_end, exp_ctrl});
    write_frame(4'b0011, 16'h1234);
    chk("R3 manual write ignored", 32'(end_addr), 32'(exp_end));

    summary();
  end
endmodule